// File: doc/BRIEF.md
# Pixel Output Formatter with Blanking

This block is the last digital stage between a 12-bit converter and the parallel pixel bus. Each converter sample enters a fixed delay line, so that a pixel appears on the bus a set number of data-clock cycles after it was taken. A preblanking strobe enters the same delay line. When a blanked pixel reaches the output, the block puts out a replacement value: either zero or a whole-LSB form of the black-clamp target.

The replacement value, or the pixel itself, can then be Gray coded. It is registered on the rising or the falling data-clock edge, or sent through a transparent path that does no retiming. Two controls govern the bus drivers. One makes the bus high-impedance, shown here as a low output-enable. The other forces the whole output to a static inactive state.

The control bits are expected to stay steady while pixels stream. A change to them acts on the output stage at once; it is not carried down the delay line.

Top module: `pix_out_formatter`

## Requirements
- R1: In the default mode (rising edge, no bypass), a sample present before rising edge k appears on `pixOut` right after rising edge k+14. That is 15 rising edges, counting the edge that captures it.
- R2: A blanked pixel is output as 0x000 when `blankUseClamp` is 0.
- R3: A blanked pixel is output as `clampTarget` shifted right by 2 and zero-extended to 12 bits when `blankUseClamp` is 1. For example, 0x3FF gives 0x0FF and 0x2A7 gives 0x0A9.
- R4: A pixel is blanked when `blankStrobe` equals `blankActHigh`. With `blankActHigh`=0 the strobe is active low; with 1 it is active high.
- R5: With `grayEnable`=1 the output is v XOR (v>>1), where v is the value after blank substitution. So a clamp blank of 0x3FF comes out as 0x080.
- R6: With `fallEdgeSel`=1 the output register loads on the falling edge. A sample appears after the falling edge that follows rising edge k+13, half a cycle ahead of R1.
- R7: With `latchBypass`=1 the output is transparent. A sample appears right after rising edge k+13, whatever `fallEdgeSel` says.
- R8: With `outOff`=1, `pixOe` is 0 while `pixOut` still carries the formatted pixel.
- R9: With `outCtl`=0, `pixOut` is 0x000 and `pixOe` is 0, whatever the other controls say.
- R10: The blank strobe passes through the same delay as the data. A strobe active in the cycle of sample k blanks exactly output k and no neighbour.
- R11: A synchronous reset (`rstN` low at a rising edge) clears the delay line and the output register. After reset `pixOut` stays 0x000 until the first captured sample reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleIn | input | 12 | Raw converter sample |
| blankStrobe | input | 1 | Preblanking strobe, aligned with the sample |
| clampTarget | input | 10 | Clamp target in quarter-LSB steps |
| blankActHigh | input | 1 | 1: strobe active high, 0: active low |
| blankUseClamp | input | 1 | 1: blank to clamp level, 0: blank to zero |
| grayEnable | input | 1 | 1: Gray code the output |
| fallEdgeSel | input | 1 | 1: register output on falling edge |
| latchBypass | input | 1 | 1: transparent output path |
| outOff | input | 1 | 1: bus in high-impedance |
| outCtl | input | 1 | 0: outputs held static inactive |
| pixOut | output | 12 | Pixel bus |
| pixOe | output | 1 | Bus drive enable |

## Verification
Blank substitution and Gray coding can act on the same output cycle. When they do, the order between them decides what appears on the bus. The bench runs a stream of ascending pixels with Gray coding and clamp-mode blanking enabled, and raises the strobe for one sample only. It then expects the Gray code of the shifted clamp target at exactly that output, and the Gray code of the unblanked pixel at each neighbour. This shows both the order of operations and the alignment of the strobe through the delay line.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;

  // Strobes from the control decode to the datapath output stage.
  typedef struct packed {
    logic blankNow;   // aligned blank flag at the tap of the delay line
    logic useClamp;   // substitute clamp level rather than zero
    logic grayOn;     // Gray code the output word
    logic fallEdge;   // take the falling-edge register
    logic bypass;     // transparent path, no retiming
    logic forceIdle;  // hold the bus at zero
  } fmt_strobe_t;

endpackage

// File: rtl/pix_fmt_ctrl.sv
module pix_fmt_ctrl
  import pix_fmt_pkg::*;
#(
  parameter int LAT = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blankStrobe,
  input  logic        blankActHigh,
  input  logic        blankUseClamp,
  input  logic        grayEnable,
  input  logic        fallEdgeSel,
  input  logic        latchBypass,
  input  logic        outOff,
  input  logic        outCtl,
  output fmt_strobe_t strobe,
  output logic        driveEn
);

  localparam int DEPTH = LAT - 1;

  logic             blankHit;
  logic [DEPTH-1:0] blankPipe;

  // Polarity is folded in before the delay, so the pipe always holds "blank".
  assign blankHit = ~(blankStrobe ^ blankActHigh);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankPipe <= '0;
    end else begin
      blankPipe[0] <= blankHit;
      for (int s = 1; s < DEPTH; s++) begin
        blankPipe[s] <= blankPipe[s-1];
      end
    end
  end

  always_comb begin
    strobe.blankNow  = blankPipe[DEPTH-1];
    strobe.useClamp  = blankUseClamp;
    strobe.grayOn    = grayEnable;
    strobe.fallEdge  = fallEdgeSel;
    strobe.bypass    = latchBypass;
    strobe.forceIdle = ~outCtl;
  end

  assign driveEn = outCtl & ~outOff;

endmodule

// File: rtl/pix_fmt_dpath.sv
module pix_fmt_dpath
  import pix_fmt_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LAT         = 15,
  parameter int CLAMP_W     = 10,
  parameter int CLAMP_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  sampleIn,
  input  logic [CLAMP_W-1:0] clampTarget,
  input  fmt_strobe_t        strobe,
  output logic [DATA_W-1:0]  pixOut
);

  localparam int DEPTH      = LAT - 1;
  localparam int CLAMP_KEEP = CLAMP_W - CLAMP_SHIFT;

  logic [DATA_W-1:0] stageQ [DEPTH];
  logic [DATA_W-1:0] tapData;
  logic [DATA_W-1:0] clampWhole;
  logic [DATA_W-1:0] preVal;
  logic [DATA_W-1:0] grayVal;
  logic [DATA_W-1:0] codedVal;
  logic [DATA_W-1:0] riseQ;
  logic [DATA_W-1:0] fallQ;
  logic [DATA_W-1:0] selVal;
  logic              unusedClampLsb;

  // Delay line: stage 0 captures the raw sample, the rest shift it on.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= sampleIn;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  assign tapData = stageQ[DEPTH-1];

  // Quarter-LSB target to whole-LSB code.
  assign unusedClampLsb = ^clampTarget[CLAMP_SHIFT-1:0];
  always_comb begin
    clampWhole = '0;
    clampWhole[CLAMP_KEEP-1:0] = clampTarget[CLAMP_W-1:CLAMP_SHIFT];
  end

  // Blank substitution comes before the optional Gray coding.
  always_comb begin
    if (strobe.blankNow) preVal = strobe.useClamp ? clampWhole : '0;
    else                 preVal = tapData;
  end

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_gray
      if (b == DATA_W - 1) begin : g_msb
        assign grayVal[b] = preVal[b];
      end else begin : g_low
        assign grayVal[b] = preVal[b] ^ preVal[b+1];
      end
    end
  endgenerate

  assign codedVal = strobe.grayOn ? grayVal : preVal;

  always_ff @(posedge clk) begin
    if (!rstN) riseQ <= '0;
    else       riseQ <= codedVal;
  end

  always_ff @(negedge clk) begin
    if (!rstN) fallQ <= '0;
    else       fallQ <= codedVal;
  end

  always_comb begin
    if (strobe.bypass)        selVal = codedVal;
    else if (strobe.fallEdge) selVal = fallQ;
    else                      selVal = riseQ;
  end

  assign pixOut = strobe.forceIdle ? '0 : selVal;

  // ---------------------------------------------------------------- checks
  logic cfgRise;
  logic cfgOther;
  assign cfgRise  = !strobe.fallEdge && !strobe.bypass && !strobe.forceIdle;
  assign cfgOther = strobe.fallEdge || strobe.bypass || strobe.forceIdle;

  p_zero_blank_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blankNow && !strobe.useClamp && cfgRise |=> cfgOther || pixOut == '0)
    else $error("blank to zero not seen on bus");

  p_clamp_blank_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blankNow && strobe.useClamp && !strobe.grayOn && cfgRise
    |=> cfgOther || pixOut == $past(clampWhole))
    else $error("blank to clamp level not seen on bus");

  p_gray_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.blankNow && strobe.grayOn && cfgRise &&
    $past(!strobe.blankNow && strobe.grayOn && cfgRise) &&
    (tapData == $past(tapData) + 1'b1)
    |=> cfgOther || $countones(pixOut ^ $past(pixOut)) == 1)
    else $error("Gray coded neighbours differ in more than one bit");

endmodule

// File: rtl/pix_out_formatter.sv
module pix_out_formatter
  import pix_fmt_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LAT         = 15,
  parameter int CLAMP_W     = 10,
  parameter int CLAMP_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  sampleIn,
  input  logic               blankStrobe,
  input  logic [CLAMP_W-1:0] clampTarget,
  input  logic               blankActHigh,
  input  logic               blankUseClamp,
  input  logic               grayEnable,
  input  logic               fallEdgeSel,
  input  logic               latchBypass,
  input  logic               outOff,
  input  logic               outCtl,
  output logic [DATA_W-1:0]  pixOut,
  output logic               pixOe
);

  fmt_strobe_t ctlStrobe;
  logic        driveEn;

  pix_fmt_ctrl #(
    .LAT(LAT)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .blankStrobe  (blankStrobe),
    .blankActHigh (blankActHigh),
    .blankUseClamp(blankUseClamp),
    .grayEnable   (grayEnable),
    .fallEdgeSel  (fallEdgeSel),
    .latchBypass  (latchBypass),
    .outOff       (outOff),
    .outCtl       (outCtl),
    .strobe       (ctlStrobe),
    .driveEn      (driveEn)
  );

  pix_fmt_dpath #(
    .DATA_W     (DATA_W),
    .LAT        (LAT),
    .CLAMP_W    (CLAMP_W),
    .CLAMP_SHIFT(CLAMP_SHIFT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .sampleIn   (sampleIn),
    .clampTarget(clampTarget),
    .strobe     (ctlStrobe),
    .pixOut     (pixOut)
  );

  assign pixOe = driveEn;

  p_oe_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    outOff |-> !pixOe)
    else $error("bus enabled while off");

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outCtl |-> (pixOut == '0) && !pixOe)
    else $error("bus not idle while output control cleared");

endmodule

// File: tb/sim_pix_out_formatter.sv
`timescale 1ns/1ps
module sim_pix_out_formatter;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] sampleIn;
  logic        blankStrobe;
  logic [9:0]  clampTarget;
  logic        blankActHigh, blankUseClamp, grayEnable;
  logic        fallEdgeSel, latchBypass, outOff, outCtl;
  logic [11:0] pixOut;
  logic        pixOe;

  int runCnt  = 0;
  int failCnt = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pix_out_formatter u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .blankStrobe(blankStrobe),
    .clampTarget(clampTarget), .blankActHigh(blankActHigh),
    .blankUseClamp(blankUseClamp), .grayEnable(grayEnable),
    .fallEdgeSel(fallEdgeSel), .latchBypass(latchBypass), .outOff(outOff),
    .outCtl(outCtl), .pixOut(pixOut), .pixOe(pixOe)
  );

  typedef struct packed {
    logic [11:0] smp;
    logic        stb;
    logic [9:0]  clamp;
    logic        actHi, useCl, gray, fall, byp, off, ctl;
    logic [11:0] expOut;
    logic        expOe;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{12'hABC, 1'b1, 10'h000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 12'hABC, 1'b1, 4'd1},  // R1 plain
    '{12'hABC, 1'b0, 10'h000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 12'h000, 1'b1, 4'd2},  // R2 R4 low strobe
    '{12'hABC, 1'b1, 10'h3FF, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 12'h0FF, 1'b1, 4'd3},  // R3 R4 high strobe
    '{12'hABC, 1'b0, 10'h2A7, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 12'h0A9, 1'b1, 4'd3},  // R3
    '{12'hABC, 1'b0, 10'h2A7, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 12'hABC, 1'b1, 4'd4},  // R4 inactive
    '{12'h800, 1'b1, 10'h000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 12'hC00, 1'b1, 4'd5},  // R5
    '{12'h5A5, 1'b1, 10'h000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 12'h777, 1'b1, 4'd5},  // R5
    '{12'hABC, 1'b1, 10'h3FF, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 12'h080, 1'b1, 4'd5},  // R5 after blank
    '{12'h123, 1'b1, 10'h000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 12'h123, 1'b1, 4'd6},  // R6
    '{12'h456, 1'b1, 10'h000, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 12'h456, 1'b1, 4'd7},  // R7
    '{12'h789, 1'b1, 10'h000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h789, 1'b0, 4'd8},  // R8
    '{12'hFFF, 1'b1, 10'h000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 12'h000, 1'b0, 4'd9},  // R9
    '{12'hABC, 1'b1, 10'h3FF, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 12'h000, 1'b0, 4'd9}   // R9 overrides
  };

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    runCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] toGray(input logic [11:0] v);
    return v ^ (v >> 1);
  endfunction

  task automatic setPlain();
    blankStrobe = 1'b1; blankActHigh = 1'b0; blankUseClamp = 1'b0;
    grayEnable = 1'b0; fallEdgeSel = 1'b0; latchBypass = 1'b0;
    outOff = 1'b0; outCtl = 1'b1; clampTarget = '0;
  endtask

  // One-cycle pulse through the delay, sampled early and late in each cycle.
  task automatic impulse(input logic fall, input logic byp, input string tag);
    logic [11:0] e5, e15;
    fallEdgeSel = fall; latchBypass = byp; sampleIn = '0;
    repeat (20) @(posedge clk);
    #2 sampleIn = 12'h5C3;
    for (int k = 1; k <= 16; k++) begin
      @(posedge clk);
      #2;
      if (k == 1) sampleIn = '0;
      e5  = (byp ? (k == 14) : (k == 15)) ? 12'h5C3 : 12'h000;
      e15 = ((byp || fall) ? (k == 14) : (k == 15)) ? 12'h5C3 : 12'h000;
      #3;
      if (k >= 13) check(tag, pixOut, e5);
      #10;
      if (k >= 13) check(tag, pixOut, e15);
    end
    fallEdgeSel = 1'b0; latchBypass = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failCnt++;
      runCnt++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    setPlain();
    sampleIn = 12'hFFF;
    repeat (3) @(posedge clk);
    #15;
    check("R11 in reset", pixOut, 12'h000);
    check("R11 oe in reset", {11'b0, pixOe}, 12'h001);
    @(posedge clk);
    #2 rstN = 1'b1;
    repeat (10) @(posedge clk);
    #13;
    check("R11 drained pipe", pixOut, 12'h000);
    repeat (8) @(posedge clk);
    #13;
    check("R1 after reset", pixOut, 12'hFFF);

    // Steady-state vector walk.
    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk);
      #2;
      sampleIn = VECS[v].smp; blankStrobe = VECS[v].stb; clampTarget = VECS[v].clamp;
      blankActHigh = VECS[v].actHi; blankUseClamp = VECS[v].useCl;
      grayEnable = VECS[v].gray; fallEdgeSel = VECS[v].fall;
      latchBypass = VECS[v].byp; outOff = VECS[v].off; outCtl = VECS[v].ctl;
      repeat (17) @(posedge clk);
      #15;
      runCnt++;
      if (pixOut !== VECS[v].expOut || pixOe !== VECS[v].expOe) begin
        failCnt++;
        $display("FAIL R%0d vector %0d: got %h/%b expected %h/%b",
                 VECS[v].req, v, pixOut, pixOe, VECS[v].expOut, VECS[v].expOe);
      end
    end

    // R1 R6 R7: latency of a single pulse per output mode.
    @(posedge clk);
    #2 setPlain();
    impulse(1'b0, 1'b0, "R1 rising latency");
    impulse(1'b1, 1'b0, "R6 falling latency");
    impulse(1'b0, 1'b1, "R7 bypass latency");
    impulse(1'b1, 1'b1, "R7 bypass over falling");

    // R10 with R5: one-sample blank on a Gray coded ramp.
    @(posedge clk);
    #2;
    grayEnable = 1'b1; blankUseClamp = 1'b1; blankActHigh = 1'b1;
    clampTarget = 10'h3FF; blankStrobe = 1'b0; sampleIn = '0;
    repeat (20) @(posedge clk);
    for (int k = 0; k < 24; k++) begin
      @(posedge clk);
      #2;
      if (k < 20) begin
        sampleIn = 12'h100 + 12'(k);
        blankStrobe = (k == 5);
      end else begin
        blankStrobe = 1'b0;
      end
      #13;
      if (k >= 18 && k <= 22) begin
        check("R10 blank alignment", pixOut,
              (k - 15 == 5) ? toGray(12'h0FF) : toGray(12'h100 + 12'(k - 15)));
      end
    end

    // R11: reset in mid-stream clears the output register.
    @(posedge clk);
    #2 setPlain(); sampleIn = 12'h3C3;
    repeat (17) @(posedge clk);
    #13;
    check("R1 before mid reset", pixOut, 12'h3C3);
    #9 rstN = 1'b0;
    @(posedge clk);
    #15;
    check("R11 mid reset", pixOut, 12'h000);
    #7 rstN = 1'b1;
    repeat (5) @(posedge clk);
    #15;
    check("R11 refill", pixOut, 12'h000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule